// File: doc/BRIEF.md
# Burst-Based Frame Memory Reader

The block fetches one frame of memory words from external memory through a memory-mapped read master that issues bursts. It places the returned words in a local FIFO, from which a downstream unpacker drains them. A frame is described by a byte start address and a word count, both taken on a one-cycle `start` pulse. The block walks the frame from the lowest address upward and sizes each burst from a fixed target length. The last burst is cut to the words that are still left. A burst goes out only when the FIFO can absorb all of it together with every word already in flight.

On the output side the FIFO presents one word per transfer on a valid/ready pair. A word leaves when `out_valid` and `out_ready` are both high at a rising edge. While `out_ready` is low the block keeps `out_valid` and `out_data` unchanged, so back-pressure can last any number of cycles. If back-pressure lasts long enough, the FIFO fills and the block stops issuing bursts. `frame_done` pulses once after the last word of the frame has been written into the FIFO. A single clock runs the whole block. Reset is active high, asserts asynchronously and is released in step with the clock.

Top module: `frame_burst_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, `mm_read`, `out_valid`, `busy` and `frame_done` are all low.
- R2: The first burst of a frame carries the start address. Every later burst starts at the previous burst's address plus its word count times the word width in bytes (WORD_W/8).
- R3: Each burst count is the smaller of BURST_MAX and the words not yet requested. The counts of one frame add up exactly to the programmed word count.
- R4: When a burst is accepted, the words accepted but not yet popped from the output, plus the new burst count, are at most FIFO_DEPTH. The FIFO never overflows.
- R5: While `mm_waitrequest` is high, an asserted `mm_read` stays high and `mm_address` and `mm_burstcount` do not change.
- R6: A word is taken from `mm_readdata` only in a cycle with `mm_readdatavalid` high. Words come out of the output in the order they were returned, which is ascending address order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle. A word is removed only on `out_valid && out_ready`.
- R8: `frame_done` is high for exactly one cycle, the cycle after the edge that wrote the frame's last word into the FIFO. `busy` is low in that same cycle.
- R9: A `start` pulse while `busy` is high is ignored. The running frame keeps its address and word count.
- R10: A frame with a word count of zero raises `frame_done` in the cycle after `start` and issues no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high reset, asynchronous assert |
| start | input | 1 | One-cycle request to begin a frame |
| start_addr | input | ADDR_W | Byte address of the frame's first word |
| word_count | input | CNT_W | Number of memory words in the frame |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse when the last word is buffered |
| mm_address | output | ADDR_W | Read master byte address |
| mm_burstcount | output | BC_W | Words in the current burst |
| mm_read | output | 1 | Read request |
| mm_waitrequest | input | 1 | Fabric stalls the request |
| mm_readdata | input | WORD_W | Returned read data |
| mm_readdatavalid | input | 1 | `mm_readdata` holds a valid word |
| out_data | output | WORD_W | Buffered word |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Consumer takes the word |

## Verification
Every frame length from 0 to 19 words is read with a 4-word burst target and an 8-deep FIFO. This covers an empty frame, frames shorter than one burst, exact multiples of the burst target, and frames with a clipped final burst. Each length runs under three timing patterns:
- no stall and a consumer that is always ready;
- alternating wait states with a slow consumer, which fills the FIFO and exercises the space gate;
- long wait stretches with gapped return data, which separates request holding from the acceptance of return data.

A second `start` issued in the middle of a frame shows that a busy reader ignores new programming.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {FBR_IDLE = 1'b0, FBR_RUN = 1'b1} fbr_state_e;

  function automatic int clip_len(int left, int target);
    return (left < target) ? left : target;
  endfunction
endpackage

// File: rtl/fbr_fifo.sv
module fbr_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 64,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             pop;

  assign pop      = rd_valid && rd_ready;
  assign rd_valid = (level != '0);
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      level <= CW'(int'(level) + (wr_en ? 1 : 0) - (pop ? 1 : 0));
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(level) < DEPTH));

  p_hold_out_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/fbr_burst_ctrl.sv
module fbr_burst_ctrl
  import fbr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int BURST_MAX  = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int BYTES      = 8,
  localparam int BC_W = $clog2(BURST_MAX + 1),
  localparam int LW   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [LW-1:0]     fifo_level,
  input  logic              mm_waitrequest,
  input  logic              mm_readdatavalid,
  output logic              mm_read,
  output logic [ADDR_W-1:0] mm_address,
  output logic [BC_W-1:0]   mm_burstcount,
  output logic              push,
  output logic              busy,
  output logic              frame_done
);
  fbr_state_e        state;
  logic [ADDR_W-1:0] next_addr;
  logic [CNT_W-1:0]  req_left, rx_left;
  logic [LW-1:0]     outst;
  logic [BC_W-1:0]   len;
  logic              accepted, can_issue;

  assign busy     = (state == FBR_RUN);
  assign accepted = mm_read && !mm_waitrequest;
  assign push     = busy && mm_readdatavalid && (rx_left != '0);

  always_comb begin
    len       = BC_W'(clip_len(int'(req_left), BURST_MAX));
    can_issue = busy && !mm_read && (req_left != '0) &&
                ((FIFO_DEPTH - int'(fifo_level) - int'(outst)) >= int'(len));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state         <= FBR_IDLE;
      next_addr     <= '0;
      req_left      <= '0;
      rx_left       <= '0;
      outst         <= '0;
      mm_read       <= 1'b0;
      mm_address    <= '0;
      mm_burstcount <= '0;
      frame_done    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          next_addr <= start_addr;
          req_left  <= word_count;
          rx_left   <= word_count;
          outst     <= '0;
          if (word_count == '0) frame_done <= 1'b1;
          else                  state      <= FBR_RUN;
        end
      end else begin
        if (accepted) mm_read <= 1'b0;
        if (can_issue) begin
          mm_read       <= 1'b1;
          mm_address    <= next_addr;
          mm_burstcount <= len;
          next_addr     <= next_addr + ADDR_W'(len) * ADDR_W'(BYTES);
          req_left      <= req_left - CNT_W'(len);
        end
        outst <= LW'(int'(outst) + (accepted ? int'(mm_burstcount) : 0) - (push ? 1 : 0));
        if (push) begin
          rx_left <= rx_left - 1'b1;
          if (rx_left == CNT_W'(1)) begin
            state      <= FBR_IDLE;
            frame_done <= 1'b1;
          end
        end
      end
    end
  end

  p_hold_req_r5: assert property (@(posedge clk) disable iff (rst)
    (mm_read && mm_waitrequest) |=> (mm_read && $stable(mm_address) && $stable(mm_burstcount)));

  p_burst_len_r3: assert property (@(posedge clk) disable iff (rst)
    mm_read |-> (mm_burstcount != '0 && int'(mm_burstcount) <= BURST_MAX));

  p_space_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mm_read) |-> (int'(fifo_level) + int'(outst) + int'(mm_burstcount) <= FIFO_DEPTH));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mm_read);
endmodule

// File: rtl/frame_burst_reader.sv
module frame_burst_reader #(
  parameter int WORD_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int BURST_MAX  = 32,
  parameter int FIFO_DEPTH = 64,
  localparam int BYTES = WORD_W / 8,
  localparam int BC_W  = $clog2(BURST_MAX + 1),
  localparam int LW    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              frame_done,
  output logic [ADDR_W-1:0] mm_address,
  output logic [BC_W-1:0]   mm_burstcount,
  output logic              mm_read,
  input  logic              mm_waitrequest,
  input  logic [WORD_W-1:0] mm_readdata,
  input  logic              mm_readdatavalid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [LW-1:0] level;
  logic          push;

  fbr_burst_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_MAX(BURST_MAX),
    .FIFO_DEPTH(FIFO_DEPTH), .BYTES(BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .fifo_level(level),
    .mm_waitrequest(mm_waitrequest), .mm_readdatavalid(mm_readdatavalid),
    .mm_read(mm_read), .mm_address(mm_address), .mm_burstcount(mm_burstcount),
    .push(push), .busy(busy), .frame_done(frame_done)
  );

  fbr_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(mm_readdata),
    .rd_data(out_data), .rd_valid(out_valid), .rd_ready(out_ready),
    .level(level)
  );
endmodule

// File: tb/test_frame_burst_reader.sv
module test_frame_burst_reader;
  localparam int WORD_W = 16, ADDR_W = 20, CNT_W = 12, BMAX = 4, DEPTH = 8;
  localparam int BYTES = WORD_W / 8;
  localparam int BC_W  = $clog2(BMAX + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  word_count = '0;
  logic busy, frame_done, mm_read, out_valid;
  logic [ADDR_W-1:0] mm_address;
  logic [BC_W-1:0]   mm_burstcount;
  logic mm_waitrequest = 1'b0, mm_readdatavalid = 1'b0, out_ready = 1'b0;
  logic [WORD_W-1:0] mm_readdata = '0, out_data;

  frame_burst_reader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .BURST_MAX(BMAX), .FIFO_DEPTH(DEPTH)) i_frame_burst_reader (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int pat = 0, cur_wc = 0, cur_word = 0;
  int acc_words = 0, rx_words = 0, popped = 0, done_seen = 0, cycles = 0;
  int pend [256];
  int head = 0, tail = 0;
  bit chk_done = 0, prev_stall = 0, model_on = 0;
  logic [WORD_W-1:0] prev_data = '0;

  function automatic logic [WORD_W-1:0] mem_word(int w);
    return WORD_W'(w * 7919 + 3);
  endfunction

  function automatic bit wait_fn(int p, int c);
    return (p == 0) ? 1'b0 : (p == 1) ? ((c % 2) == 1) : ((c % 3) != 0);
  endfunction
  function automatic bit rdv_fn(int p, int c);
    return (p == 0) ? 1'b1 : (p == 1) ? ((c % 3) != 2) : ((c % 2) == 0);
  endfunction
  function automatic bit rdy_fn(int p, int c);
    return (p == 0) ? 1'b1 : (p == 1) ? ((c % 3) == 0) : ((c % 4) != 3);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory, fabric and consumer model, active on falling edges
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (model_on) begin
        if (chk_done) begin
          check(frame_done && !busy, "R8 done pulse after last word", int'(frame_done), 1);
          chk_done = 0;
        end
        if (frame_done) done_seen++;
        // return data from bursts accepted earlier
        if (head != tail && rdv_fn(pat, cycles)) begin
          mm_readdatavalid = 1'b1;
          mm_readdata = mem_word(pend[head % 256]);
          head++;
          rx_words++;
          if (rx_words == cur_wc) chk_done = 1;
        end else begin
          mm_readdatavalid = 1'b0;
          mm_readdata = 16'hDEAD;   // R6 garbage that must not be taken
        end
        // request side
        mm_waitrequest = wait_fn(pat, cycles);
        if (mm_read && !mm_waitrequest) begin
          check(int'(mm_address) == cur_word * BYTES + acc_words * BYTES,
                "R2 burst address", int'(mm_address), cur_word * BYTES + acc_words * BYTES);
          check(int'(mm_burstcount) == fbr_pkg::clip_len(cur_wc - acc_words, BMAX),
                "R3 burst count", int'(mm_burstcount), fbr_pkg::clip_len(cur_wc - acc_words, BMAX));
          check(acc_words - popped + int'(mm_burstcount) <= DEPTH,
                "R4 space for burst", acc_words - popped + int'(mm_burstcount), DEPTH);
          for (int i = 0; i < int'(mm_burstcount); i++) begin
            pend[tail % 256] = int'(mm_address) / BYTES + i;
            tail++;
          end
          acc_words += int'(mm_burstcount);
        end
        // consumer side
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R7 hold under back-pressure",
                int'(out_data), int'(prev_data));
        out_ready = rdy_fn(pat, cycles);
        if (out_valid && out_ready) begin
          check(out_data == mem_word(cur_word + popped), "R6 output order",
                int'(out_data), int'(mem_word(cur_word + popped)));
          popped++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

  task automatic run_frame(int p, int wc, int base_word, bit interrupt);
    @(negedge clk);
    pat = p; cur_wc = wc; cur_word = base_word;
    acc_words = 0; rx_words = 0; popped = 0; done_seen = 0;
    head = 0; tail = 0; chk_done = 0; prev_stall = 0;
    start = 1'b1; start_addr = ADDR_W'(base_word * BYTES); word_count = CNT_W'(wc);
    @(negedge clk);
    start = 1'b0;
    if (wc == 0) begin
      check(frame_done == 1'b1, "R10 empty frame done", int'(frame_done), 1);
      check(!mm_read && !busy, "R10 no request", int'(mm_read), 0);
      @(negedge clk);
      check(frame_done == 1'b0, "R8 single-cycle pulse", int'(frame_done), 0);
      return;
    end
    if (interrupt) begin
      repeat (4) @(negedge clk);
      start = 1'b1; start_addr = ADDR_W'(12345 * BYTES); word_count = CNT_W'(3);
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 2000 && !(done_seen > 0 && popped == wc); t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(acc_words == wc, "R3 total requested", acc_words, wc);
    check(popped == wc, "R6 all words delivered", popped, wc);
    check(done_seen == 1, "R8 one pulse per frame", done_seen, 1);
    check(!busy && !mm_read && !out_valid, interrupt ? "R9 late start ignored" : "R8 idle after frame",
          int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mm_read && !out_valid && !busy && !frame_done, "R1 state in reset", int'(mm_read), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mm_read && !out_valid && !busy && !frame_done, "R1 state after reset", int'(busy), 0);
    model_on = 1;
    for (int p = 0; p < 3; p++)
      for (int wc = 0; wc < 20; wc++)
        run_frame(p, wc, 100 * p + 7 * wc + 16, 1'b0);
    run_frame(1, 18, 500, 1'b1);
    run_frame(2, 9, 900, 1'b1);
    finish_sim();
  end
endmodule